// File: doc/BRIEF.md
# Load Return Data Merge Unit

This unit builds the value a load writes back once its cache line has arrived. It takes the full line, the load's byte offset inside that line, its access size and a sign-extension flag. It also takes any bytes already supplied by an older store together with a per-byte valid mask. Store bytes take priority over line bytes, one byte at a time. The merged bytes are then moved to the least significant end of the destination register. The bytes above the access size are filled according to the extension flag.

The result goes into a single register stage. One cycle after a request, the unit gives a one-cycle writeback strobe, the destination register tag and the final value. The core uses the strobe both to write the register file and to wake dependent operations in the issue queues. There is no backpressure, so each request cycle produces exactly one strobe cycle. An access that runs past the end of the line is not handled: its strobe carries an error flag and a zero value. The line width, register width and tag width are parameters. The register must be at least 8 bytes wide.

Top module: `ldret_merge_unit`

## Requirements
- R1: While reset is asserted, and on the first clock after its release with no request, `wb_vld` and `wb_err` are 0.
- R2: Line byte k is `line_data[8k+7:8k]`. Result byte i, for i below the access size, is line byte `req_off + i` when its mask bit is clear.
- R3: When `fwd_mask[i]` is set, result byte i is byte i of `fwd_data` (bits `8i+7:8i`), for every i below the access size. Mask bits at or above the access size have no effect.
- R4: `req_size` encodes the access size: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes.
- R5: With `req_sext` = 0, every result byte at or above the access size is zero.
- R6: With `req_sext` = 1, every result byte at or above the access size is 0xFF if bit 7 of the highest accessed byte is set after merging, and 0x00 otherwise.
- R7: When the mask is set for every accessed byte, the result does not depend on `line_data`.
- R8: If `req_off` plus the access size exceeds the line size in bytes, the strobe carries `wb_err` = 1 and `wb_data` = 0. Otherwise `wb_err` = 0.
- R9: `wb_vld` is high in exactly the cycle after each cycle in which `req_vld` is high, and low otherwise. Back-to-back requests give back-to-back strobes.
- R10: `wb_tag` in a strobe cycle equals the `req_tag` of the request that caused it.
- R11: In a cycle with no request, `wb_data`, `wb_tag` and `wb_err` keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | A load return request is present this cycle |
| line_data | input | LINE_BYTES*8 | Arrived cache line, byte 0 in the low bits |
| req_off | input | $clog2(LINE_BYTES) | Byte offset of the load within the line |
| req_size | input | 2 | Access size code (0:1, 1:2, 2:4, 3:8 bytes) |
| req_sext | input | 1 | 1 for sign extension, 0 for zero extension |
| req_tag | input | TAG_W | Destination register tag |
| fwd_data | input | REG_BYTES*8 | Store-forwarded bytes, load-relative byte order |
| fwd_mask | input | REG_BYTES | Per-byte valid mask for `fwd_data` |
| wb_vld | output | 1 | One-cycle writeback and wakeup strobe |
| wb_tag | output | TAG_W | Destination register tag of the result |
| wb_data | output | REG_BYTES*8 | Aligned, merged and extended load value |
| wb_err | output | 1 | The access crossed the line boundary |

## Verification
Clocked properties check four behaviours on every cycle: the strobe timing and its single-cycle width, the tag that travels with each request, that `wb_data`, `wb_tag` and `wb_err` hold while no request is present, and that a line-crossing result is zero. Zero extension of single-byte loads is also checked by a property. The per-byte choice between store and line bytes, offset selection over the whole line, and sign extension at each size can only be shown by the bench. It compares every strobe against a separately written model, using random and directed patterns. The directed patterns cover the last valid offset, the first crossing offset, full and partial masks, and negative values at every size.

// File: rtl/ldret_pkg.sv
package ldret_pkg;

  typedef enum logic [1:0] {
    SZ_1B = 2'd0,
    SZ_2B = 2'd1,
    SZ_4B = 2'd2,
    SZ_8B = 2'd3
  } ld_size_e;

  localparam int unsigned MAX_ACCESS_BYTES = 8;

endpackage

// File: rtl/ldret_extract.sv
module ldret_extract #(
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned REG_BYTES  = 8,
  localparam int unsigned LINE_W = LINE_BYTES * 8,
  localparam int unsigned REG_W  = REG_BYTES * 8,
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES)
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [REG_W-1:0]  bytes_o
);

  logic [LINE_W-1:0] shifted;

  // Bytes past the line end shift in as zero.
  always_comb begin
    shifted = line_i >> {off_i, 3'b000};
    bytes_o = shifted[REG_W-1:0];
  end

endmodule

// File: rtl/ldret_merge.sv
module ldret_merge #(
  parameter int unsigned REG_BYTES = 8,
  localparam int unsigned REG_W = REG_BYTES * 8
) (
  input  logic [REG_W-1:0]     line_bytes_i,
  input  logic [REG_W-1:0]     fwd_bytes_i,
  input  logic [REG_BYTES-1:0] fwd_mask_i,
  output logic [REG_W-1:0]     merged_o
);

  for (genvar g = 0; g < REG_BYTES; g++) begin : g_byte
    always_comb begin
      if (fwd_mask_i[g]) merged_o[g*8 +: 8] = fwd_bytes_i[g*8 +: 8];
      else               merged_o[g*8 +: 8] = line_bytes_i[g*8 +: 8];
    end
  end

endmodule

// File: rtl/ldret_extend.sv
module ldret_extend
  import ldret_pkg::*;
#(
  parameter int unsigned REG_BYTES = 8,
  localparam int unsigned REG_W = REG_BYTES * 8
) (
  input  logic [REG_W-1:0] data_i,
  input  ld_size_e         size_i,
  input  logic             sext_i,
  output logic [REG_W-1:0] data_o
);

  logic       sign_bit;
  logic       fill_bit;
  logic [4:0] nbytes;

  always_comb begin
    sign_bit = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (size_i == ld_size_e'(k)) sign_bit = data_i[(8 << k) - 1];
    end
    fill_bit = sext_i & sign_bit;
    nbytes   = 5'd1 << size_i;
  end

  for (genvar g = 0; g < REG_BYTES; g++) begin : g_byte
    always_comb begin
      if (32'(g) < 32'(nbytes)) data_o[g*8 +: 8] = data_i[g*8 +: 8];
      else                      data_o[g*8 +: 8] = {8{fill_bit}};
    end
  end

endmodule

// File: rtl/ldret_merge_unit.sv
module ldret_merge_unit
  import ldret_pkg::*;
#(
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned REG_BYTES  = 8,
  parameter int unsigned TAG_W      = 7,
  localparam int unsigned LINE_W = LINE_BYTES * 8,
  localparam int unsigned REG_W  = REG_BYTES * 8,
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
  localparam int unsigned POS_W  = OFF_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_vld,
  input  logic [LINE_W-1:0]    line_data,
  input  logic [OFF_W-1:0]     req_off,
  input  logic [1:0]           req_size,
  input  logic                 req_sext,
  input  logic [TAG_W-1:0]     req_tag,
  input  logic [REG_W-1:0]     fwd_data,
  input  logic [REG_BYTES-1:0] fwd_mask,
  output logic                 wb_vld,
  output logic [TAG_W-1:0]     wb_tag,
  output logic [REG_W-1:0]     wb_data,
  output logic                 wb_err
);

  ld_size_e         size_e;
  logic [REG_W-1:0] line_bytes;
  logic [REG_W-1:0] merged;
  logic [REG_W-1:0] extended;
  logic [POS_W-1:0] end_pos;
  logic             cross_err;

  assign size_e = ld_size_e'(req_size);

  ldret_extract #(.LINE_BYTES(LINE_BYTES), .REG_BYTES(REG_BYTES)) u_extract (
    .line_i  (line_data),
    .off_i   (req_off),
    .bytes_o (line_bytes)
  );

  ldret_merge #(.REG_BYTES(REG_BYTES)) u_merge (
    .line_bytes_i (line_bytes),
    .fwd_bytes_i  (fwd_data),
    .fwd_mask_i   (fwd_mask),
    .merged_o     (merged)
  );

  ldret_extend #(.REG_BYTES(REG_BYTES)) u_extend (
    .data_i (merged),
    .size_i (size_e),
    .sext_i (req_sext),
    .data_o (extended)
  );

  always_comb begin
    end_pos   = POS_W'(req_off) + (POS_W'(1) << req_size);
    cross_err = end_pos > POS_W'(LINE_BYTES);
  end

  // Next-state logic
  logic             vld_d, vld_q;
  logic [TAG_W-1:0] tag_d, tag_q;
  logic [REG_W-1:0] data_d, data_q;
  logic             err_d, err_q;
  logic             cap_en;

  always_comb begin
    cap_en = req_vld;
    vld_d  = req_vld;
    tag_d  = req_tag;
    err_d  = cross_err;
    data_d = cross_err ? '0 : extended;
  end

  // Register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      tag_q  <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (cap_en) begin
        tag_q  <= tag_d;
        data_q <= data_d;
        err_q  <= err_d;
      end
    end
  end

  assign wb_vld  = vld_q;
  assign wb_tag  = tag_q;
  assign wb_data = data_q;
  assign wb_err  = err_q;

  AST_STROBE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> wb_vld); // R9
  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !wb_vld); // R9
  AST_TAG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> (wb_tag == $past(req_tag))); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> ($stable(wb_data) && $stable(wb_tag) && $stable(wb_err))); // R11
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_vld && wb_err) |-> (wb_data == '0)); // R8
  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_sext && req_size == 2'd0) |=> (wb_data[REG_W-1:8] == '0)); // R5

endmodule

// File: tb/ldret_merge_unit_tb.sv
module ldret_merge_unit_tb_top;

  localparam int  LB = 64;
  localparam int  RB = 8;
  localparam int  TW = 7;
  localparam time CLK_PERIOD = 10ns;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_vld = 1'b0;
  logic [LB*8-1:0] line_data = '0;
  logic [5:0]      req_off = '0;
  logic [1:0]      req_size = '0;
  logic            req_sext = 1'b0;
  logic [TW-1:0]   req_tag = '0;
  logic [RB*8-1:0] fwd_data = '0;
  logic [RB-1:0]   fwd_mask = '0;
  logic            wb_vld;
  logic [TW-1:0]   wb_tag;
  logic [RB*8-1:0] wb_data;
  logic            wb_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldret_merge_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .line_data(line_data),
    .req_off(req_off), .req_size(req_size), .req_sext(req_sext), .req_tag(req_tag),
    .fwd_data(fwd_data), .fwd_mask(fwd_mask), .wb_vld(wb_vld), .wb_tag(wb_tag),
    .wb_data(wb_data), .wb_err(wb_err)
  );

  function automatic logic [63:0] model(input logic [LB*8-1:0] ln, input int off,
      input int sz, input bit sx, input logic [63:0] fd, input logic [7:0] fm,
      output bit err);
    int nb = 1 << sz;
    logic [63:0] r = '0;
    bit sg;
    err = (off + nb) > LB;
    if (err) return '0;
    for (int i = 0; i < 8; i++)
      if (i < nb) r[i*8 +: 8] = fm[i] ? fd[i*8 +: 8] : ln[(off+i)*8 +: 8];
    sg = r[nb*8-1];
    for (int i = 0; i < 8; i++)
      if (i >= nb) r[i*8 +: 8] = (sx && sg) ? 8'hFF : 8'h00;
    return r;
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [LB*8-1:0] rand_line();
    logic [LB*8-1:0] l;
    for (int w = 0; w < LB/4; w++) l[w*32 +: 32] = $urandom;
    return l;
  endfunction

  bit            pend = 0;
  string         p_rq;
  logic [63:0]   p_data;
  bit            p_err;
  logic [TW-1:0] p_tag;

  task automatic check_pend();
    if (pend) begin
      chk({p_rq, "/R9 vld"}, 64'(wb_vld), 64'd1);
      chk({p_rq, "/R10 tag"}, 64'(wb_tag), 64'(p_tag));
      chk({p_rq, "/R8 err"}, 64'(wb_err), 64'(p_err));
      chk(p_rq, wb_data, p_data);
    end else begin
      chk("R9 idle", 64'(wb_vld), 64'd0);
    end
  endtask

  // Applies one request at the falling edge; checks the previous one there.
  task automatic send(input string rq, input logic [LB*8-1:0] ln, input int off,
      input int sz, input bit sx, input logic [63:0] fd, input logic [7:0] fm);
    bit e;
    @(negedge clk);
    check_pend();
    req_vld = 1'b1; line_data = ln; req_off = 6'(off); req_size = 2'(sz);
    req_sext = sx; fwd_data = fd; fwd_mask = fm; req_tag = TW'($urandom);
    p_data = model(ln, off, sz, sx, fd, fm, e);
    p_err = e; p_tag = req_tag; p_rq = rq; pend = 1;
  endtask

  task automatic idle();
    @(negedge clk);
    check_pend();
    req_vld = 1'b0; line_data = rand_line(); req_tag = TW'($urandom);
    pend = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [LB*8-1:0] ln;
    logic [63:0] hold_d;
    logic [TW-1:0] hold_t;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 vld", 64'(wb_vld), 64'd0);
    chk("R1 err", 64'(wb_err), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after", 64'(wb_vld), 64'd0);

    ln = '0;
    for (int k = 0; k < LB; k++) ln[k*8 +: 8] = 8'(k + 8'h80);
    send("R2 R4 byte", ln, 5, 0, 0, '0, '0);
    send("R4 half", ln, 10, 1, 0, '0, '0);
    send("R4 word", ln, 20, 2, 0, '0, '0);
    send("R2 R4 dword", ln, 56, 3, 0, '0, '0);
    send("R6 byte neg", ln, 0, 0, 1, '0, '0);
    send("R6 half neg", ln, 2, 1, 1, '0, '0);
    send("R6 word neg", ln, 8, 2, 1, '0, '0);
    send("R5 word", ln, 8, 2, 0, '0, '0);
    send("R6 pos via fwd", ln, 4, 1, 1, 64'h0000_0000_0000_7F00, 8'h02);
    send("R3 partial", ln, 16, 3, 0, 64'h1122_3344_5566_7788, 8'hA5);
    send("R3 mask above size", ln, 16, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFC);
    send("R7 full mask", ln, 30, 3, 1, 64'h8123_4567_89AB_CDEF, 8'hFF);
    send("R7 full mask other line", rand_line(), 30, 3, 1, 64'h8123_4567_89AB_CDEF, 8'hFF);
    send("R6 merged sign", ln, 40, 2, 1, 64'h0000_0000_9000_0000, 8'h08);
    send("R8 last fit", ln, 56, 3, 0, '0, '0);
    send("R8 cross dword", ln, 57, 3, 0, '0, '0);
    send("R8 cross half", ln, 63, 1, 1, '0, 8'hFF);
    send("R8 last byte", ln, 63, 0, 1, '0, '0);
    idle();
    hold_d = wb_data; hold_t = wb_tag;
    idle();
    chk("R11 data hold", wb_data, hold_d);
    chk("R11 tag hold", 64'(wb_tag), 64'(hold_t));

    for (int n = 0; n < 400; n++) begin
      int sz = $urandom_range(3, 0);
      int off = $urandom_range(LB-1, 0);
      logic [7:0] fm;
      case ($urandom_range(3, 0))
        0: fm = '0;
        1: fm = 8'hFF;
        default: fm = 8'($urandom);
      endcase
      if ($urandom_range(3, 0) != 0) off = off & ~((1 << sz) - 1);
      send("R2 R3 R6 random", rand_line(), off, sz, 1'($urandom),
           {$urandom, $urandom}, fm);
      if ($urandom_range(4, 0) == 0) idle();
    end
    idle();
    idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule